// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block is an 8-bit serial shift port that a CPU sets up through two write strobes. One strobe loads a data register and the other loads a small control word. On the pin side it has a shift clock, a serial input and a serial output with its own output enable. The shift clock comes from one of two sources. In internal mode the port divides the system clock and drives the shift clock out. In external mode a remote master supplies the shift clock, and the port brings it into the system clock domain through a synchronizer and detects its edges.

Bits leave least-significant first. Each falling shift-clock edge updates the serial output, and each rising edge samples the serial input into the top of the register. The two modes behave differently once a byte is done:

- **Internal mode:** the port makes exactly eight clock pulses, parks the clock high and floats the data output by itself.
- **External mode:** the port shifts on every incoming edge with no limit. It wraps its bit counter every eight edges and keeps driving the data output until software asks it to float. That request takes effect only while the incoming clock is high.

Control word written on `ctrl_wdata` and read on `ctrl_q`:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | run | Enables the port. Clearing it aborts a transfer. |
| 1 | tx enable | Allows an internal-mode transfer to start. |
| 2 | external clock | Selects the external shift clock. |
| 3 | float request | Asks for the serial output to go high-impedance. |
| 4 | irq | Reads the interrupt flag. Writing 0 clears it; writing 1 leaves it unchanged. |

Top module: `sio_port`

## Requirements
- R1: In internal mode (ctrl bit 2 = 0), a started transfer produces exactly eight low pulses on `sck_out`. `sdo` presents bits 0..7 of the written byte, each changing on a falling edge. `sdi` is sampled on each rising edge into bit 7 while the register shifts right. `sck_out` then stays high.
- R2: `irq` becomes 1 when eight rising shift edges have been counted, in either mode. It stays 1 until a control write with bit 4 = 0.
- R3: In internal mode, `sdo_oe` goes to 0 on its own when the eighth bit completes, whatever the float request bit.
- R4: In external mode, the register shifts on every rising edge of `sck_in`, including edges beyond the eighth. The counter wraps every eight edges, and `irq` sets again at each wrap.
- R5: In external mode, `sdo_oe` stays 1 after the eighth bit. With float request bit 3 = 1, `sdo_oe` drops only while `sck_in` is high. It stays 1 while `sck_in` is held low.
- R6: While idle in internal mode with run set, `sdo_oe` is 1 when float request is 0 and 0 when float request is 1.
- R7: Writing run = 0 aborts a transfer. `sck_out` stays high, `sdo_oe` is 0 and `irq` does not set. Writing run = 1 afterwards leaves `data_q` unchanged.
- R8: In external mode, a data write, or a control write that sets tx enable from 0 to 1, is ignored while `sck_in` is low and accepted while it is high.
- R9: In internal mode, a data write with tx enable = 0 loads `data_q` but produces no shift clock.
- R10: After reset, `data_q` = 0, `ctrl_q` = 0, `irq` = 0, `sck_out` = 1, `sck_oe` = 0 and `sdo_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 1 | Data register write strobe |
| data_wdata | input | BITS | Byte to load |
| wr_ctrl | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control word {irq keep, float, ext, tx enable, run} |
| data_q | output | BITS | Shift register contents |
| ctrl_q | output | 5 | {irq, float, ext, tx enable, run} |
| irq | output | 1 | Transfer-complete interrupt flag |
| sck_in | input | 1 | External shift clock pin |
| sck_out | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Shift clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The hardest behaviour to reach from the ports depends on the level of an asynchronous external clock. This covers the gating of data writes, tx-enable sets and float requests in external mode. The bench reaches it by parking `sck_in` low for many cycles, issuing the writes, and only then raising the clock. It observes `data_q`, `ctrl_q` and `sdo_oe` in both phases. A mid-transfer abort is reached by starting an internal transfer and clearing run after a few shift edges. The bench then confirms that the clock stays parked and no interrupt follows.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int CB_RUN  = 0;
  localparam int CB_TXEN = 1;
  localparam int CB_EXT  = 2;
  localparam int CB_FLT  = 3;
  localparam int CB_IRQ  = 4;
  localparam int CW_BITS = 5;

  // rising-edge step of the bit counter, wrapping after 'bits' edges
  function automatic int unsigned bit_step(input int unsigned cur, input int unsigned bits);
    return (cur == bits - 1) ? 0 : cur + 1;
  endfunction

  // a tx-enable set is refused in external mode while the clock is low
  function automatic logic txen_refused(input logic ext_new, input logic txen_new,
                                        input logic txen_old, input logic sck_high);
    return ext_new & txen_new & ~txen_old & ~sck_high;
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int DW = $clog2(DIV_HALF + 1);
  logic [DW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == DW'(DIV_HALF - 1));
  assign rise = tick & ~sck;
  assign fall = tick & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!en) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + DW'(1);
    end
  end
endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= level;
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            rise,
  input  logic            fall,
  input  logic            clr_cnt,
  input  logic            sdi,
  output logic [BITS-1:0] data,
  output logic            sdo_bit,
  output logic            wrap
);
  import sio_pkg::*;
  localparam int CW = $clog2(BITS);
  logic [CW-1:0] cnt;

  assign wrap = rise && (cnt == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      sdo_bit <= 1'b1;
      cnt     <= '0;
    end else if (load) begin
      data    <= load_val;
      sdo_bit <= load_val[0];
      cnt     <= '0;
    end else begin
      if (rise) begin
        data <= {sdi, data[BITS-1:1]};
        cnt  <= CW'(bit_step(int'(cnt), BITS));
      end
      if (fall) sdo_bit <= data[0];
      if (clr_cnt) cnt <= '0;
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int BITS        = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_data,
  input  logic [BITS-1:0] data_wdata,
  input  logic            wr_ctrl,
  input  logic [4:0]      ctrl_wdata,
  output logic [BITS-1:0] data_q,
  output logic [4:0]      ctrl_q,
  output logic            irq,
  input  logic            sck_in,
  output logic            sck_out,
  output logic            sck_oe,
  input  logic            sdi,
  output logic            sdo,
  output logic            sdo_oe
);
  import sio_pkg::*;

  logic run_q, txen_q, ext_q, flt_q, busy_q, float_q;
  logic sck_hi, e_rise, e_fall;
  logic c_sck, c_rise, c_fall;
  logic rise_evt, fall_evt, wrap_evt;
  logic data_wr_ok, start, done_int, txen_block;

  sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in),
    .level(sck_hi), .rise(e_rise), .fall(e_fall)
  );

  sio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(busy_q),
    .sck(c_sck), .rise(c_rise), .fall(c_fall)
  );

  assign rise_evt   = run_q & (ext_q ? e_rise : c_rise);
  assign fall_evt   = run_q & (ext_q ? e_fall : c_fall);
  assign data_wr_ok = wr_data & (ext_q ? sck_hi : ~busy_q);
  assign start      = data_wr_ok & ~ext_q & txen_q & run_q;
  assign done_int   = wrap_evt & ~ext_q;
  assign txen_block = txen_refused(ctrl_wdata[CB_EXT], ctrl_wdata[CB_TXEN], txen_q, sck_hi);

  sio_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(data_wr_ok), .load_val(data_wdata),
    .rise(rise_evt), .fall(fall_evt), .clr_cnt(~run_q),
    .sdi(sdi), .data(data_q), .sdo_bit(sdo), .wrap(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      txen_q <= 1'b0;
      ext_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= ctrl_wdata[CB_RUN];
      ext_q  <= ctrl_wdata[CB_EXT];
      flt_q  <= ctrl_wdata[CB_FLT];
      txen_q <= txen_block ? txen_q : ctrl_wdata[CB_TXEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (wrap_evt)           irq <= 1'b1;
    else if (wr_ctrl && !ctrl_wdata[CB_IRQ]) irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_q <= 1'b0;
    else if (!run_q || ext_q)  busy_q <= 1'b0;
    else if (start)            busy_q <= 1'b1;
    else if (wrap_evt)         busy_q <= 1'b0;
  end

  // float state: set on internal completion or by a float request that
  // meets its clock condition; cleared by an accepted data write or request=0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    float_q <= 1'b0;
    else if (done_int)                             float_q <= 1'b1;
    else if (data_wr_ok)                           float_q <= 1'b0;
    else if (wr_ctrl && !ctrl_wdata[CB_FLT])       float_q <= 1'b0;
    else if (flt_q && run_q && (!ext_q || sck_hi)) float_q <= 1'b1;
  end

  assign sdo_oe  = run_q & (busy_q | ~float_q);
  assign sck_out = ext_q ? 1'b1 : c_sck;
  assign sck_oe  = run_q & ~ext_q;
  assign ctrl_q  = {irq, flt_q, ext_q, txen_q, run_q};
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rise_evt,
  input logic            fall_evt,
  input logic            wrap_evt,
  input logic            busy_q,
  input logic            run_q,
  input logic            ext_q,
  input logic            txen_q,
  input logic            sck_hi,
  input logic            irq,
  input logic            sck_out,
  input logic            sdo_oe,
  input logic            wr_data,
  input logic            wr_ctrl,
  input logic [4:0]      ctrl_wdata,
  input logic [BITS-1:0] data_q
);
  assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));

  assert_clock_parks_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_out);

  assert_int_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !ext_q) |=> !busy_q);

  assert_irq_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> irq);

  assert_abort_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sdo_oe);

  assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !busy_q);

  assert_ext_data_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ext_q && !sck_hi) |=> $stable(data_q));

  assert_ext_txen_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_wdata[2] && ctrl_wdata[1] && !txen_q && !sck_hi) |=> !txen_q);
endmodule

bind sio_port sio_port_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .wrap_evt(wrap_evt), .busy_q(busy_q), .run_q(run_q), .ext_q(ext_q),
  .txen_q(txen_q), .sck_hi(sck_hi), .irq(irq), .sck_out(sck_out),
  .sdo_oe(sdo_oe), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
  .ctrl_wdata(ctrl_wdata), .data_q(data_q)
);

// File: tb/sim_sio_port.sv
module sim_sio_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_data = 0, wr_ctrl = 0, sck_in = 1, sdi = 0;
  logic [7:0] data_wdata = 0;
  logic [4:0] ctrl_wdata = 0;
  logic [7:0] data_q;
  logic [4:0] ctrl_q;
  logic irq, sck_out, sck_oe, sdo, sdo_oe;
  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mdl;

  always #5 clk = ~clk;

  sio_port u0 (.clk(clk), .rst_n(rst_n), .wr_data(wr_data), .data_wdata(data_wdata),
    .wr_ctrl(wr_ctrl), .ctrl_wdata(ctrl_wdata), .data_q(data_q), .ctrl_q(ctrl_q),
    .irq(irq), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe));

  // control word: bit4 keep irq, bit3 float, bit2 ext, bit1 tx enable, bit0 run
  function automatic logic [4:0] cw(input logic run, input logic txen,
                                    input logic ext, input logic flt, input logic keep);
    return {keep, flt, ext, txen, run};
  endfunction

  function automatic logic [7:0] shift_model(input logic [7:0] d, input logic b);
    return {b, d[7:1]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    @(negedge clk); wr_ctrl = 1; ctrl_wdata = v;
    @(negedge clk); wr_ctrl = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); wr_data = 1; data_wdata = v;
    @(negedge clk); wr_data = 0;
  endtask

  // internal-mode transfer acting as the remote slave
  task automatic int_xfer(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got = 0;
    int k = 0, rises = 0;
    logic prev = 1;
    wr_dat(tx);
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (prev && !sck_out) begin
        if (k < 8) begin got[k] = sdo; sdi = rx[k]; end
        k++;
      end
      if (!prev && sck_out) rises++;
      prev = sck_out;
    end
    chk("R1 sdo bit sequence", got, tx);
    chk("R1 rising edge count", rises, 8);
    chk("R1 received byte", data_q, rx);
    chk("R1 clock parked high", sck_out, 1);
    chk("R2 irq after 8 bits", irq, 1);
    chk("R3 auto float", sdo_oe, 0);
  endtask

  task automatic ext_edge(input logic b);
    logic exp_sdo;
    exp_sdo = mdl[0];
    @(negedge clk); sck_in = 0; sdi = b;
    idle(6);
    chk("R4 ext sdo bit", sdo, exp_sdo);
    sck_in = 1;
    idle(6);
    mdl = shift_model(mdl, b);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] saved;
    void'($urandom(32'd4242));
    idle(3); rst_n = 1; idle(2);
    // R10 reset state
    chk("R10 data", data_q, 0);
    chk("R10 ctrl", ctrl_q, 0);
    chk("R10 irq", irq, 0);
    chk("R10 sck_out", sck_out, 1);
    chk("R10 sck_oe", sck_oe, 0);
    chk("R10 sdo_oe", sdo_oe, 0);

    // R6 idle output control
    wr_ctl(cw(1, 0, 0, 0, 1)); idle(3);
    chk("R6 idle drive", sdo_oe, 1);
    wr_ctl(cw(1, 0, 0, 1, 1)); idle(3);
    chk("R6 idle float", sdo_oe, 0);

    // R9 load without tx enable
    wr_ctl(cw(1, 0, 0, 0, 1));
    wr_dat(8'hA5);
    begin
      int lows = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (!sck_out) lows++; end
      chk("R9 no clock", lows, 0);
    end
    chk("R9 data loaded", data_q, 8'hA5);
    chk("R9 no irq", irq, 0);

    // R1/R2/R3 internal transfers: directed then random
    wr_ctl(cw(1, 1, 0, 0, 1));
    int_xfer(8'h01, 8'h80);
    wr_ctl(cw(1, 1, 0, 0, 0)); idle(2);
    chk("R2 irq cleared", irq, 0);
    int_xfer(8'h80, 8'h01);
    wr_ctl(cw(1, 1, 0, 0, 0));
    for (int n = 0; n < 4; n++) begin
      int_xfer(8'($urandom), 8'($urandom));
      wr_ctl(cw(1, 1, 0, 0, 0));
    end

    // R7 abort mid transfer
    wr_dat(8'h5A); idle(14);
    wr_ctl(cw(0, 1, 0, 0, 1)); idle(2);
    saved = data_q;
    begin
      int lows = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (!sck_out) lows++; end
      chk("R7 clock parked", lows, 0);
    end
    chk("R7 sdo_oe off", sdo_oe, 0);
    chk("R7 no irq", irq, 0);
    wr_ctl(cw(1, 1, 0, 0, 1)); idle(3);
    chk("R7 data kept", data_q, saved);

    // R4/R5 external mode
    wr_ctl(cw(1, 1, 1, 0, 0)); idle(4);
    wr_dat(8'hC3); mdl = 8'hC3; idle(2);
    for (int i = 0; i < 8; i++) ext_edge(1'($urandom));
    chk("R2 ext irq", irq, 1);
    chk("R4 ext byte", data_q, mdl);
    chk("R5 still driven", sdo_oe, 1);
    wr_ctl(cw(1, 1, 1, 0, 0)); idle(2);
    for (int i = 0; i < 5; i++) ext_edge(1'($urandom));
    chk("R4 no early irq", irq, 0);
    chk("R4 keeps shifting", data_q, mdl);
    for (int i = 0; i < 3; i++) ext_edge(1'($urandom));
    chk("R4 irq on wrap", irq, 1);

    // R5 float gated by clock level
    @(negedge clk); sck_in = 0; idle(6);
    wr_ctl(cw(1, 1, 1, 1, 1)); idle(10);
    chk("R5 float held off while low", sdo_oe, 1);
    sck_in = 1; idle(6);
    chk("R5 float while high", sdo_oe, 0);

    // R8 write gating in external mode
    wr_ctl(cw(1, 0, 1, 0, 1)); idle(3);
    saved = data_q;
    @(negedge clk); sck_in = 0; idle(6);
    wr_dat(8'h3C); idle(2);
    chk("R8 data ignored low", data_q, saved);
    wr_ctl(cw(1, 1, 1, 0, 1)); idle(2);
    chk("R8 txen ignored low", ctrl_q[1], 0);
    sck_in = 1; idle(6);
    wr_dat(8'h3C); idle(2);
    chk("R8 data accepted high", data_q, 8'h3C);
    wr_ctl(cw(1, 1, 1, 0, 1)); idle(2);
    chk("R8 txen accepted high", ctrl_q[1], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule